// File: doc/BRIEF.md
# Compare Status Flag Generator

This unit evaluates a comparison between two operands by forming destination minus source and keeping only the status it produces. The difference itself is thrown away. Six status bits come out of it: carry (borrow), auxiliary carry, overflow, parity, sign and zero. They sit in a flag register that holds its value until the next accepted operation. A width select picks either full 16-bit operands or the low byte only.

Besides the comparison, the unit carries out the carry-only operations: clear, set and invert. It also accepts a packed status byte that overwrites five of the flags at once. The same five flags, packed into one byte, are always visible on an 8-bit output. Operand fetch and opcode decode happen upstream. The unit sees one operation per cycle, qualified by a valid strobe.

Top module: `cmp_flag_unit`

## Requirements
- R1: After reset all six flags are 0 and the packed status byte reads 0x02.
- R2: On a compare (op code 0), the carry flag is 1 exactly when the destination, read as an unsigned number of the selected width, is less than the source.
- R3: On a compare, the auxiliary flag is 1 exactly when the low nibble of the destination is less than the low nibble of the source.
- R4: On a compare, the overflow flag is 1 exactly when the operand sign bits differ and the sign bit of the difference differs from the sign bit of the destination.
- R5: On a compare, the parity flag is 1 exactly when the low byte of the difference holds an even number of one bits.
- R6: On a compare, the sign flag equals the top bit of the difference at the selected width, and the zero flag is 1 exactly when that difference is zero.
- R7: With the width select low (byte mode), the upper 8 bits of both operands have no effect on any flag.
- R8: Op code 1 clears carry, op code 2 sets carry and op code 3 inverts carry, and the other five flags are left unchanged.
- R9: Op code 4 loads sign from bit 7, zero from bit 6, auxiliary from bit 4, parity from bit 2 and carry from bit 0 of the status byte input, and leaves overflow unchanged.
- R10: The packed status byte output shows sign at bit 7, zero at bit 6, auxiliary at bit 4, parity at bit 2 and carry at bit 0. Bits 5 and 3 read 0 and bit 1 reads 1.
- R11: Flags change only on the clock edge that samples the valid strobe high. With the strobe low, or with op codes 5 to 7, every flag holds its value.
- R12: Comparing 0x1234 with 0xABCD at full width gives zero 0, sign 0, overflow 0, carry 1, auxiliary 1 and parity 0 (the difference is 0x6667).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Op code: 0 compare, 1 clear carry, 2 set carry, 3 invert carry, 4 load status byte |
| wide_i | input | 1 | 1 for 16-bit operands, 0 for byte operands |
| dst_i | input | 16 | Destination operand |
| src_i | input | 16 | Source operand |
| flag_byte_i | input | 8 | Packed status byte to load |
| cf_o | output | 1 | Carry (borrow) flag |
| af_o | output | 1 | Auxiliary carry flag |
| of_o | output | 1 | Overflow flag |
| pf_o | output | 1 | Parity flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| flag_byte_o | output | 8 | Packed status byte |

## Verification
The bench aims at the places where a width error shows. In byte mode it fills the upper operand bytes with garbage. A unit that took carry, sign or zero from bit 15 would then report a borrow or a non-zero result that does not exist. Signed-overflow edges (0x8000 minus 1, 0x7F minus 0xFF) catch an overflow rule built on the wrong sign bit. Nibble borrows such as 0x10 minus 0x01 catch an auxiliary flag taken from the wrong bit. A status-byte load with overflow already set shows whether the load wrongly overwrites overflow. Reserved op codes and idle cycles expose a register that updates without a qualified strobe.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

   typedef enum logic [2:0] {
      OP_CMP  = 3'd0,
      OP_CLRC = 3'd1,
      OP_SETC = 3'd2,
      OP_TGLC = 3'd3,
      OP_PUTF = 3'd4
   } cmpf_op_e;

   typedef struct packed {
      logic sf;
      logic zf;
      logic af;
      logic pf;
      logic cf;
      logic of;
   } cmpf_flags_t;

endpackage

// File: rtl/cmpf_sub.sv
module cmpf_sub #(
   parameter int W     = 16,
   parameter int AUX_W = 4,
   parameter int PAR_W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         borrow_o,
   output logic         aux_o,
   output logic         ovf_o,
   output logic         sign_o,
   output logic         zero_o,
   output logic         even_o
);
   localparam int MSB = W - 1;

   logic [W:0]       full_d;
   logic [AUX_W:0]   nib_d;
   logic [W-1:0]     diff;

   always_comb begin
      full_d   = {1'b0, a_i} - {1'b0, b_i};
      nib_d    = {1'b0, a_i[AUX_W-1:0]} - {1'b0, b_i[AUX_W-1:0]};
      diff     = full_d[W-1:0];
      borrow_o = full_d[W];
      aux_o    = nib_d[AUX_W];
      sign_o   = diff[MSB];
      zero_o   = (diff == '0);
      ovf_o    = (a_i[MSB] ^ b_i[MSB]) & (diff[MSB] ^ a_i[MSB]);
      even_o   = ~(^diff[PAR_W-1:0]);
   end
endmodule

// File: rtl/cmpf_pack.sv
module cmpf_pack
   import cmpf_pkg::*;
(
   input  cmpf_flags_t flags_i,
   output logic [7:0]  byte_o
);
   localparam logic BIT5_VAL = 1'b0;
   localparam logic BIT3_VAL = 1'b0;
   localparam logic BIT1_VAL = 1'b1;

   assign byte_o = {flags_i.sf, flags_i.zf, BIT5_VAL, flags_i.af,
                    BIT3_VAL, flags_i.pf, BIT1_VAL, flags_i.cf};
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
   import cmpf_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter int AUX_W    = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  logic [2:0]        op_i,
   input  logic              wide_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [7:0]        flag_byte_i,
   output logic              cf_o,
   output logic              af_o,
   output logic              of_o,
   output logic              pf_o,
   output logic              sf_o,
   output logic              zf_o,
   output logic [7:0]        flag_byte_o
);
   localparam int PAR_W = NARROW_W;

   generate
      if (NARROW_W >= DATA_W || AUX_W >= NARROW_W || NARROW_W < 8) begin : g_bad_cfg
         $error("cmp_flag_unit: need AUX_W < NARROW_W < DATA_W and NARROW_W >= 8");
      end
   endgenerate

   logic [1:0] v_borrow, v_aux, v_ovf, v_sign, v_zero, v_even;

   // index 0: byte variant, index 1: full-width variant
   generate
      for (genvar gi = 0; gi < 2; gi++) begin : g_width
         localparam int VW = (gi == 0) ? NARROW_W : DATA_W;
         cmpf_sub #(.W(VW), .AUX_W(AUX_W), .PAR_W(PAR_W)) sub_i (
            .a_i      (dst_i[VW-1:0]),
            .b_i      (src_i[VW-1:0]),
            .borrow_o (v_borrow[gi]),
            .aux_o    (v_aux[gi]),
            .ovf_o    (v_ovf[gi]),
            .sign_o   (v_sign[gi]),
            .zero_o   (v_zero[gi]),
            .even_o   (v_even[gi])
         );
      end
   endgenerate

   cmpf_flags_t cmp_f, nxt_f, cur_f;

   always_comb begin
      cmp_f.cf = v_borrow[wide_i];
      cmp_f.af = v_aux[wide_i];
      cmp_f.of = v_ovf[wide_i];
      cmp_f.sf = v_sign[wide_i];
      cmp_f.zf = v_zero[wide_i];
      cmp_f.pf = v_even[wide_i];
   end

   always_comb begin
      nxt_f = cur_f;
      if (valid_i) begin
         case (op_i)
            OP_CMP:  nxt_f = cmp_f;
            OP_CLRC: nxt_f.cf = 1'b0;
            OP_SETC: nxt_f.cf = 1'b1;
            OP_TGLC: nxt_f.cf = ~cur_f.cf;
            OP_PUTF: begin
               nxt_f.sf = flag_byte_i[7];
               nxt_f.zf = flag_byte_i[6];
               nxt_f.af = flag_byte_i[4];
               nxt_f.pf = flag_byte_i[2];
               nxt_f.cf = flag_byte_i[0];
            end
            default: nxt_f = cur_f;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) cur_f <= '0;
      else         cur_f <= nxt_f;
   end

   cmpf_pack pack_i (
      .flags_i (cur_f),
      .byte_o  (flag_byte_o)
   );

   assign cf_o = cur_f.cf;
   assign af_o = cur_f.af;
   assign of_o = cur_f.of;
   assign pf_o = cur_f.pf;
   assign sf_o = cur_f.sf;
   assign zf_o = cur_f.zf;

   p_borrow_wide_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_CMP && wide_i && dst_i < src_i) |=> cf_o)
      else $error("p_borrow_wide_r2");

   p_equal_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_CMP && wide_i && dst_i == src_i) |=> (zf_o && !cf_o && !sf_o))
      else $error("p_equal_zero_r6");

   p_clear_carry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_CLRC) |=> (!cf_o && $stable(zf_o) && $stable(of_o)))
      else $error("p_clear_carry_r8");

   p_set_carry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_SETC) |=> cf_o)
      else $error("p_set_carry_r8");

   p_toggle_carry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_TGLC) |=> (cf_o != $past(cf_o)))
      else $error("p_toggle_carry_r8");

   p_load_byte_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_PUTF) |=> ($stable(of_o) && sf_o == $past(flag_byte_i[7])
                                        && cf_o == $past(flag_byte_i[0])))
      else $error("p_load_byte_r9");

   p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!valid_i) |=> $stable(flag_byte_o) && $stable(of_o))
      else $error("p_idle_hold_r11");
endmodule

// File: tb/cmp_flag_unit_tb_top.sv
module cmp_flag_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        valid;
   logic [2:0]  op;
   logic        wide;
   logic [15:0] dst, src;
   logic [7:0]  fbyte_in;
   logic        cf, af, ovf, pf, sf, zf;
   logic [7:0]  fbyte_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // behavioural model state
   int m_cf, m_af, m_of, m_pf, m_sf, m_zf;

   always #2.5 clk = ~clk;

   cmp_flag_unit dut_i (
      .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .wide_i(wide),
      .dst_i(dst), .src_i(src), .flag_byte_i(fbyte_in),
      .cf_o(cf), .af_o(af), .of_o(ovf), .pf_o(pf), .sf_o(sf), .zf_o(zf),
      .flag_byte_o(fbyte_out)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic int model_byte();
      return (m_sf << 7) | (m_zf << 6) | (m_af << 4) | (m_pf << 2) | 2 | m_cf;
   endfunction

   task automatic model_step(input int v, input int o, input int w, input int a,
                             input int b, input int fb);
      int mask, ai, bi, d, ones, top;
      if (v == 0) return;
      case (o)
         0: begin
            mask = (w != 0) ? 16'hFFFF : 16'h00FF;
            top  = (w != 0) ? 15 : 7;
            ai = a & mask; bi = b & mask;
            d  = (ai - bi) & mask;
            m_cf = (ai < bi) ? 1 : 0;
            m_af = ((ai & 15) < (bi & 15)) ? 1 : 0;
            m_zf = (d == 0) ? 1 : 0;
            m_sf = (d >> top) & 1;
            m_of = ((((ai >> top) & 1) != ((bi >> top) & 1)) &&
                    (((d >> top) & 1) != ((ai >> top) & 1))) ? 1 : 0;
            ones = 0;
            for (int k = 0; k < 8; k++) ones += (d >> k) & 1;
            m_pf = (ones % 2 == 0) ? 1 : 0;
         end
         1: m_cf = 0;
         2: m_cf = 1;
         3: m_cf = 1 - m_cf;
         4: begin
            m_sf = (fb >> 7) & 1; m_zf = (fb >> 6) & 1; m_af = (fb >> 4) & 1;
            m_pf = (fb >> 2) & 1; m_cf = fb & 1;
         end
         default: ;
      endcase
   endtask

   task automatic compare_all(input string tag);
      int got, exp;
      got = {26'd0, sf, zf, af, pf, cf, ovf};
      exp = (m_sf << 5) | (m_zf << 4) | (m_af << 3) | (m_pf << 2) | (m_cf << 1) | m_of;
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: flags sf,zf,af,pf,cf,of actual %06b expected %06b", tag, got, exp);
      end
      checks++;
      if (int'(fbyte_out) != model_byte()) begin
         errors++;
         $display("FAIL %s/R10: status byte actual %02h expected %02h", tag, fbyte_out, model_byte());
      end
   endtask

   // drive at a falling edge, let one rising edge update, check at next falling edge
   task automatic step(input string tag, input int v, input int o, input int w,
                       input int a, input int b, input int fb);
      valid = v[0]; op = o[2:0]; wide = w[0];
      dst = a[15:0]; src = b[15:0]; fbyte_in = fb[7:0];
      model_step(v, o, w, a, b, fb);
      @(posedge clk);
      @(negedge clk);
      compare_all(tag);
   endtask

   initial begin
      int seed;
      rst_n = 1'b0; valid = 1'b0; op = 3'd0; wide = 1'b1;
      dst = 16'h0; src = 16'h0; fbyte_in = 8'h0;
      m_cf = 0; m_af = 0; m_of = 0; m_pf = 0; m_sf = 0; m_zf = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      compare_all("R1 reset");
      checks++;
      if (fbyte_out !== 8'h02) begin
         errors++;
         $display("FAIL R1: reset byte actual %02h expected 02", fbyte_out);
      end

      // R12 worked example
      step("R12 example", 1, 0, 1, 'h1234, 'hABCD, 0);
      checks++;
      if ({zf, sf, ovf, cf, af, pf} !== 6'b000110) begin
         errors++;
         $display("FAIL R12: zf sf of cf af pf actual %06b expected 000110", {zf, sf, ovf, cf, af, pf});
      end
      step("R2 no borrow",      1, 0, 1, 'hABCD, 'h1234, 0);
      step("R6 equal wide",     1, 0, 1, 'h5A5A, 'h5A5A, 0);
      step("R4 overflow wide",  1, 0, 1, 'h8000, 'h0001, 0);
      step("R4 overflow neg",   1, 0, 1, 'h7FFF, 'hFFFF, 0);
      step("R3 nibble borrow",  1, 0, 1, 'h0010, 'h0001, 0);
      step("R5 parity odd",     1, 0, 1, 'h0007, 'h0000, 0);
      step("R5 parity even",    1, 0, 1, 'h0003, 'h0000, 0);
      // byte mode with garbage in the high bytes
      step("R7 byte equal",     1, 0, 0, 'hFF42, 'h0042, 0);
      step("R7 byte borrow",    1, 0, 0, 'h0001, 'hFF02, 0);
      step("R4 byte overflow",  1, 0, 0, 'h1280, 'h3401, 0);
      step("R7 byte sign",      1, 0, 0, 'h00FF, 'hFF00, 0);
      // carry operations
      step("R8 set carry",      1, 2, 1, 0, 0, 0);
      step("R8 toggle carry",   1, 3, 1, 0, 0, 0);
      step("R8 toggle again",   1, 3, 1, 0, 0, 0);
      step("R8 clear carry",    1, 1, 1, 0, 0, 0);
      // status byte load keeps overflow
      step("R4 set overflow",   1, 0, 1, 'h8000, 'h0001, 0);
      step("R9 load D5",        1, 4, 1, 0, 0, 'hD5);
      step("R9 load 2A",        1, 4, 1, 0, 0, 'h2A);
      step("R9 load 40",        1, 4, 1, 0, 0, 'h40);
      // hold cases
      step("R11 idle",          0, 0, 1, 'h0000, 'h0001, 'hFF);
      step("R11 idle load",     0, 4, 1, 0, 0, 'hFF);
      step("R11 reserved 5",    1, 5, 1, 'h0000, 'h0001, 'hFF);
      step("R11 reserved 7",    1, 7, 0, 'h0000, 'h0001, 'hFF);
      // mixed pattern sweep
      seed = 32'h1ACE;
      for (int n = 0; n < 400; n++) begin
         int a, b, o, w, v;
         seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
         a = seed & 'hFFFF;
         seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
         b = seed & 'hFFFF;
         o = (seed >> 16) % 8;
         if (o > 4) o = 0;
         w = (seed >> 20) & 1;
         v = ((seed >> 22) & 7) != 0 ? 1 : 0;
         step("R2 sweep", v, o, w, a, b, b >> 3);
      end
      valid = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule